// File: doc/BRIEF.md
# Far-Pointer Load/Store Address Unit

This block serves a move instruction that reaches a 32-bit, byte-addressed, little-endian data space through two 16-bit registers. For each operation it forms the access address and drives a single memory request. It returns the load data and reports the values the pointer register and the base register must take afterwards. Register storage, flag updates and instruction decoding belong to the surrounding core. The core presents the current register values together with a one-cycle strobe and writes back the reported values when the done pulse arrives.

There are two address forms. The short form joins a fixed high register, which supplies bits 31:16, with the pointer register, which supplies bits 15:0. The displacement form joins a base register with the pointer register and adds a sign-extended 12-bit immediate across all 32 bits. Each form can be used plain, with post-increment or with pre-decrement. In the displacement form, stepping the pointer register carries into the base register or borrows from it under a zero-test rule. Word accesses clear only bit 0 of the full 32-bit address.

Top module: `farptr_agu`

## Requirements
- R1: In the short form (`op_disp_form`=0) the address is `hi_reg` in bits 31:16 and the accessed pointer value in bits 15:0.
- R2: In the displacement form (`op_disp_form`=1) the address is {base, pointer} plus `imm12` sign-extended to 32 bits, and the carry or borrow of that add reaches bit 31.
- R3: For a word access (`op_word`=1) `mem_addr` bit 0 is zero and bits 31:1 are those of the computed address. For a byte access the address is presented unchanged.
- R4: A byte load returns {8'h00, `mem_rdata`[7:0]} and a word load returns `mem_rdata` whole. A byte store drives `mem_wdata` = {8'h00, `store_data`[7:0]} and a word store drives `store_data`. `load_data` is zero after a store.
- R5: Mode code 1 is post-increment. The access uses the original pointer, and `new_ptr` = pointer + 1 (byte) or + 2 (word), modulo 2^16.
- R6: Mode code 2 is pre-decrement. The pointer is reduced by 1 (byte) or 2 (word), the access uses the reduced value, and `new_ptr` reports it.
- R7: In the displacement form with post-increment, `new_base` = base + 1 exactly when the incremented pointer equals zero. Otherwise the base is unchanged.
- R8: In the displacement form with pre-decrement, a pointer that is zero before the step makes the base decrement by 1 first. The address then uses the updated base and the reduced pointer, and `new_base` reports the updated base.
- R9: In the short form `new_base` always equals the `base_reg` value supplied with the strobe, and `hi_reg` never receives a carry.
- R10: Mode code 0 (plain) and the unused code 3 leave the pointer and the base unchanged.
- R11: `mem_req` rises in the cycle after an accepted strobe and holds its address, size, direction and data until the cycle in which `mem_ack` is high. `done` is high for exactly one cycle, the cycle after that.
- R12: A strobe that arrives while `busy` is high is ignored. The operation in flight keeps its request and its results, and no new request follows it.
- R13: While reset is high and in the cycle after it, `mem_req`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_store | input | 1 | 1 = store, 0 = load |
| op_word | input | 1 | 1 = 16-bit access, 0 = byte |
| op_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 treated as plain |
| op_disp_form | input | 1 | 1 = base plus displacement form, 0 = short form |
| hi_reg | input | 16 | Fixed high register (short form) |
| base_reg | input | 16 | Base register (displacement form) |
| ptr_reg | input | 16 | Pointer register |
| imm12 | input | 12 | Signed displacement |
| store_data | input | 16 | Data to store |
| mem_req | output | 1 | Memory request |
| mem_addr | output | 32 | Byte address |
| mem_word | output | 1 | 16-bit transfer when high |
| mem_we | output | 1 | Write when high |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| done | output | 1 | Results valid |
| busy | output | 1 | Operation in flight |
| load_data | output | 16 | Load result |
| new_ptr | output | 16 | Updated pointer value |
| new_base | output | 16 | Updated base value |

## Verification
The bench aims at pointers that wrap to zero by a step of one and of two. A pointer of 0xFFFF stepped by two lands on 0x0001 and must not carry into the base, while 0xFFFF stepped by one and 0xFFFE stepped by two must carry. A design that tested the carry out of the add would fail the first case, and one that omitted the carry would fail the other two. A pre-decrement from zero must borrow before the address is formed, so a design that borrowed afterwards would access the old base page. Displacements at both ends of the signed range are added to pointers near 0xFFFF, which catches an add confined to 16 bits or a zero-extended immediate. Odd word addresses with nonzero high halves catch alignment that truncates the upper bits. Strobes injected while busy and acknowledges delayed by several cycles test that the request is held steady and that nothing extra starts.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    parameter int unsigned HALF_W = 16;
    parameter int unsigned DISP_W = 12;
    localparam int unsigned ADDR_W = 2 * HALF_W;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_RSVD    = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } seq_e;

    typedef struct packed {
        logic              store;
        logic              word;
        amode_e            mode;
        logic              disp;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] base;
        logic [HALF_W-1:0] ptr;
        logic [DISP_W-1:0] imm;
        logic [HALF_W-1:0] wdata;
    } op_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [HALF_W-1:0] ptr_new;
        logic [HALF_W-1:0] base_new;
    } agen_t;

    function automatic logic [HALF_W-1:0] step_of(input logic word);
        return word ? HALF_W'(2) : HALF_W'(1);
    endfunction

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

endpackage

// File: rtl/fpa_ptr_step.sv
module fpa_ptr_step
    import fpa_pkg::*;
(
    input  logic [HALF_W-1:0] ptr,
    input  logic [HALF_W-1:0] base,
    input  logic              word,
    input  amode_e            mode,
    input  logic              disp,
    output logic [HALF_W-1:0] ptr_acc,
    output logic [HALF_W-1:0] base_acc,
    output logic [HALF_W-1:0] ptr_new,
    output logic [HALF_W-1:0] base_new
);
    logic [HALF_W-1:0] step;
    logic [HALF_W-1:0] inc_val;
    logic [HALF_W-1:0] dec_val;

    assign step    = step_of(word);
    assign inc_val = ptr + step;
    assign dec_val = ptr - step;

    always_comb begin
        ptr_acc  = ptr;
        base_acc = base;
        ptr_new  = ptr;
        base_new = base;
        unique case (mode)
            AM_POSTINC: begin
                ptr_new = inc_val;
                // zero test on the stepped pointer, not the adder carry
                if (disp && (inc_val == '0)) base_new = base + HALF_W'(1);
            end
            AM_PREDEC: begin
                ptr_acc = dec_val;
                ptr_new = dec_val;
                if (disp && (ptr == '0)) begin
                    base_acc = base - HALF_W'(1);
                    base_new = base - HALF_W'(1);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpa_addr_gen.sv
module fpa_addr_gen
    import fpa_pkg::*;
(
    input  op_t   op,
    output agen_t gen
);
    logic [HALF_W-1:0] ptr_acc, base_acc, ptr_new, base_new;
    logic [ADDR_W-1:0] joined;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] raw;

    fpa_ptr_step u_step (
        .ptr      (op.ptr),
        .base     (op.base),
        .word     (op.word),
        .mode     (op.mode),
        .disp     (op.disp),
        .ptr_acc  (ptr_acc),
        .base_acc (base_acc),
        .ptr_new  (ptr_new),
        .base_new (base_new)
    );

    assign joined = {(op.disp ? base_acc : op.hi), ptr_acc};
    assign offset = op.disp ? sext_disp(op.imm) : '0;
    assign raw    = joined + offset;

    always_comb begin
        gen.addr     = raw;
        gen.addr[0]  = raw[0] & ~op.word;
        gen.ptr_new  = ptr_new;
        gen.base_new = base_new;
    end
endmodule

// File: rtl/fpa_seq.sv
module fpa_seq
    import fpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic accept,
    output logic capture,
    output logic req,
    output logic fin,
    output logic busy
);
    seq_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_REQ;
            ST_REQ:  if (ack)   state_d = ST_DONE;
            ST_DONE:            state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign accept  = (state_q == ST_IDLE) && start;
    assign req     = (state_q == ST_REQ);
    assign capture = req && ack;
    assign fin     = (state_q == ST_DONE);
    assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/fpa_load_fmt.sv
module fpa_load_fmt
    import fpa_pkg::*;
(
    input  logic              store,
    input  logic              word,
    input  logic [HALF_W-1:0] rdata,
    output logic [HALF_W-1:0] data
);
    always_comb begin
        if (store)     data = '0;
        else if (word) data = rdata;
        else           data = {{(HALF_W-BYTE_W){1'b0}}, rdata[BYTE_W-1:0]};
    end
endmodule

// File: rtl/farptr_agu.sv
module farptr_agu
    import fpa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_valid,
    input  logic                        op_store,
    input  logic                        op_word,
    input  logic [1:0]                  op_mode,
    input  logic                        op_disp_form,
    input  logic [fpa_pkg::HALF_W-1:0]  hi_reg,
    input  logic [fpa_pkg::HALF_W-1:0]  base_reg,
    input  logic [fpa_pkg::HALF_W-1:0]  ptr_reg,
    input  logic [fpa_pkg::DISP_W-1:0]  imm12,
    input  logic [fpa_pkg::HALF_W-1:0]  store_data,
    output logic                        mem_req,
    output logic [fpa_pkg::ADDR_W-1:0]  mem_addr,
    output logic                        mem_word,
    output logic                        mem_we,
    output logic [fpa_pkg::HALF_W-1:0]  mem_wdata,
    input  logic                        mem_ack,
    input  logic [fpa_pkg::HALF_W-1:0]  mem_rdata,
    output logic                        done,
    output logic                        busy,
    output logic [fpa_pkg::HALF_W-1:0]  load_data,
    output logic [fpa_pkg::HALF_W-1:0]  new_ptr,
    output logic [fpa_pkg::HALF_W-1:0]  new_base
);
    op_t               op_in, op_q;
    agen_t             gen_d, gen_q;
    logic [HALF_W-1:0] fmt_data, load_q;
    logic              accept, capture;

    always_comb begin
        op_in.store = op_store;
        op_in.word  = op_word;
        op_in.mode  = amode_e'(op_mode);
        op_in.disp  = op_disp_form;
        op_in.hi    = hi_reg;
        op_in.base  = base_reg;
        op_in.ptr   = ptr_reg;
        op_in.imm   = imm12;
        op_in.wdata = store_data;
    end

    fpa_addr_gen u_gen (
        .op  (op_in),
        .gen (gen_d)
    );

    fpa_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (op_valid),
        .ack     (mem_ack),
        .accept  (accept),
        .capture (capture),
        .req     (mem_req),
        .fin     (done),
        .busy    (busy)
    );

    fpa_load_fmt u_fmt (
        .store (op_q.store),
        .word  (op_q.word),
        .rdata (mem_rdata),
        .data  (fmt_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            gen_q  <= '0;
            load_q <= '0;
        end else begin
            if (accept) begin
                op_q  <= op_in;
                gen_q <= gen_d;
            end
            if (capture) load_q <= fmt_data;
        end
    end

    assign mem_addr  = gen_q.addr;
    assign mem_word  = op_q.word;
    assign mem_we    = op_q.store;
    assign mem_wdata = op_q.word ? op_q.wdata
                                 : {{(HALF_W-BYTE_W){1'b0}}, op_q.wdata[BYTE_W-1:0]};
    assign load_data = load_q;
    assign new_ptr   = gen_q.ptr_new;
    assign new_base  = gen_q.base_new;
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker
    import fpa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_word,
    input logic              mem_we,
    input logic [HALF_W-1:0] mem_wdata,
    input logic              done,
    input logic              busy,
    input logic [HALF_W-1:0] load_data,
    input logic [HALF_W-1:0] new_base,
    input logic              q_store,
    input logic              q_word,
    input logic              q_disp,
    input logic [HALF_W-1:0] q_base
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_word) && $stable(mem_wdata));

    a_r11_done_follows_ack: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> done);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_word_even: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_word |-> !mem_addr[0]);

    a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        done && !q_store && !q_word |-> load_data[HALF_W-1:BYTE_W] == '0);

    a_r4_store_no_load: assert property (@(posedge clk) disable iff (rst)
        done && q_store |-> load_data == '0);

    a_r9_short_base: assert property (@(posedge clk) disable iff (rst)
        done && !q_disp |-> new_base == q_base);

    a_r12_no_restart: assert property (@(posedge clk) disable iff (rst)
        done |=> !mem_req);

    a_r13_reset_quiet: assert property (@(posedge clk)
        rst |=> !mem_req && !done && !busy);
endmodule

bind farptr_agu fpa_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_word  (mem_word),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .done      (done),
    .busy      (busy),
    .load_data (load_data),
    .new_base  (new_base),
    .q_store   (op_q.store),
    .q_word    (op_q.word),
    .q_disp    (op_q.disp),
    .q_base    (op_q.base)
);

// File: tb/farptr_agu_bench.sv
module farptr_agu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_store = 1'b0, op_word = 1'b0, op_disp_form = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic [15:0] hi_reg = '0, base_reg = '0, ptr_reg = '0, store_data = '0;
    logic [11:0] imm12 = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, mem_word, mem_we, done, busy;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, load_data, new_ptr, new_base;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    farptr_agu u_farptr_agu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_store(op_store),
        .op_word(op_word), .op_mode(op_mode), .op_disp_form(op_disp_form),
        .hi_reg(hi_reg), .base_reg(base_reg), .ptr_reg(ptr_reg), .imm12(imm12),
        .store_data(store_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_word(mem_word), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .busy(busy),
        .load_data(load_data), .new_ptr(new_ptr), .new_base(new_base)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_model(input logic [31:0] a);
        return (a[15:0] * 16'd3) ^ a[31:16] ^ 16'h5AC3;
    endfunction

    // behavioural reference: integer arithmetic straight from the requirements
    task automatic model(input bit wd, input int mode, input bit dsp,
                         input int unsigned hi, input int unsigned base,
                         input int unsigned ptr, input int unsigned imm,
                         output logic [31:0] addr, output logic [15:0] nptr,
                         output logic [15:0] nbase);
        int unsigned step = wd ? 2 : 1;
        int unsigned pa = ptr, ba = base, np = ptr, nb = base;
        longint a;
        int s;
        if (mode == 1) begin
            np = (ptr + step) % 65536;
            if (dsp && np == 0) nb = (base + 1) % 65536;
        end else if (mode == 2) begin
            if (dsp && ptr == 0) ba = (base + 65535) % 65536;
            pa = (ptr + 65536 - step) % 65536;
            np = pa; nb = ba;
        end
        if (dsp) begin
            s = (imm >= 2048) ? int'(imm) - 4096 : int'(imm);
            a = (longint'(ba) * 65536 + longint'(pa) + longint'(s)) & 64'hFFFF_FFFF;
        end else begin
            a = longint'(hi) * 65536 + longint'(pa);
        end
        if (wd) a = a & ~64'd1;
        addr = a[31:0]; nptr = np[15:0]; nbase = nb[15:0];
    endtask

    task automatic run_op(input string tag, input bit st, input bit wd, input int mode,
                          input bit dsp, input logic [15:0] hi, input logic [15:0] base,
                          input logic [15:0] ptr, input logic [11:0] imm,
                          input logic [15:0] sdat, input int waits, input bit spur);
        logic [31:0] e_addr;
        logic [15:0] e_ptr, e_base, e_load, rd;
        model(wd, mode, dsp, hi, base, ptr, imm, e_addr, e_ptr, e_base);
        @(negedge clk);
        op_valid = 1; op_store = st; op_word = wd; op_mode = mode[1:0];
        op_disp_form = dsp; hi_reg = hi; base_reg = base; ptr_reg = ptr;
        imm12 = imm; store_data = sdat;
        @(negedge clk);
        op_valid = 0;
        chk({tag, " R11 req"}, {31'd0, mem_req}, 32'd1);
        chk({tag, " R1/R2/R3 addr"}, mem_addr, e_addr);
        chk({tag, " R11 size"}, {31'd0, mem_word}, {31'd0, wd});
        chk({tag, " R11 dir"}, {31'd0, mem_we}, {31'd0, st});
        if (st) chk({tag, " R4 wdata"}, {16'd0, mem_wdata}, {16'd0, wd ? sdat : {8'd0, sdat[7:0]}});
        if (spur) begin
            op_valid = 1; ptr_reg = ~ptr; base_reg = ~base; hi_reg = ~hi; op_mode = 2'd1;
        end
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            op_valid = 0;
            chk({tag, " R11 hold"}, {31'd0, mem_req}, 32'd1);
            chk({tag, " R12 addr steady"}, mem_addr, e_addr);
        end
        rd = mem_model(mem_addr);
        mem_ack = 1; mem_rdata = rd;
        e_load = st ? 16'd0 : (wd ? rd : {8'd0, rd[7:0]});
        @(negedge clk);
        op_valid = 0; mem_ack = 0; mem_rdata = 16'hDEAD;
        chk({tag, " R11 done"}, {31'd0, done}, 32'd1);
        chk({tag, " R4 load"}, {16'd0, load_data}, {16'd0, e_load});
        chk({tag, " R5/R6/R10 ptr"}, {16'd0, new_ptr}, {16'd0, e_ptr});
        chk({tag, " R7/R8/R9 base"}, {16'd0, new_base}, {16'd0, e_base});
        @(negedge clk);
        chk({tag, " R11 done pulse"}, {31'd0, done}, 32'd0);
        chk({tag, " R12 no restart"}, {30'd0, mem_req, busy}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        chk("R13 reset req", {31'd0, mem_req}, 32'd0);
        chk("R13 reset done", {31'd0, done}, 32'd0);
        chk("R13 reset busy", {31'd0, busy}, 32'd0);
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R13 after reset", {30'd0, mem_req, busy}, 32'd0);

        run_op("R1 short word",        0, 1, 0, 0, 16'h1234, 16'h0000, 16'h5679, 12'h000, 16'h0, 0, 0);
        run_op("R4 short byte odd",    0, 0, 0, 0, 16'h1234, 16'h0000, 16'h5679, 12'h000, 16'h0, 1, 0);
        run_op("R9 short postinc",     0, 1, 1, 0, 16'h00AB, 16'h7777, 16'hFFFE, 12'h000, 16'h0, 0, 0);
        run_op("R6 short predec",      0, 0, 2, 0, 16'h8001, 16'h0042, 16'h0000, 12'h000, 16'h0, 2, 1);
        run_op("R2 disp negative",     0, 1, 0, 1, 16'h0000, 16'h0001, 16'h0100, 12'h800, 16'h0, 0, 0);
        run_op("R3 disp carry",        0, 1, 0, 1, 16'h0000, 16'h0002, 16'hFFF0, 12'h7FF, 16'h0, 0, 0);
        run_op("R7 disp byte carry",   0, 0, 1, 1, 16'h0000, 16'h1000, 16'hFFFF, 12'h004, 16'h0, 3, 1);
        run_op("R7 disp word nocarry", 0, 1, 1, 1, 16'h0000, 16'h1000, 16'hFFFF, 12'h000, 16'h0, 0, 0);
        run_op("R7 disp word wrap",    0, 1, 1, 1, 16'h0000, 16'hFFFF, 16'hFFFE, 12'hFFF, 16'h0, 1, 0);
        run_op("R8 disp borrow",       0, 1, 2, 1, 16'h0000, 16'h2000, 16'h0000, 12'h010, 16'h0, 0, 0);
        run_op("R8 disp noborrow",     0, 0, 2, 1, 16'h0000, 16'h2000, 16'h0001, 12'h000, 16'h0, 0, 0);
        run_op("R8 base zero borrow",  1, 1, 2, 1, 16'h0000, 16'h0000, 16'h0000, 12'h003, 16'hBEEF, 2, 0);
        run_op("R4 byte store",        1, 0, 1, 0, 16'h4321, 16'h0000, 16'h00FF, 12'h000, 16'hA5C3, 0, 1);
        run_op("R5 word store",        1, 1, 1, 1, 16'h0000, 16'h0033, 16'h1235, 12'h001, 16'h9876, 1, 0);
        run_op("R10 mode3 plain",      0, 1, 3, 1, 16'h0000, 16'h0055, 16'h0000, 12'h002, 16'h0, 0, 0);

        for (int n = 0; n < 60; n++) begin
            int m = $urandom_range(0, 3);
            logic [15:0] p;
            case ($urandom_range(0, 3))
                0: p = 16'h0000;
                1: p = 16'hFFFF;
                2: p = 16'hFFFE;
                default: p = 16'($urandom);
            endcase
            run_op("R2 random", 1'($urandom), 1'($urandom), m, 1'($urandom),
                   16'($urandom), 16'($urandom), p, 12'($urandom), 16'($urandom),
                   $urandom_range(0, 3), 1'($urandom));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule